// File: doc/BRIEF.md
# Freeze Sequencing Controller

This block decides when a freezer cartridge takes control of a running 6502-family machine. A qualified press of the freeze button arms the block. The button must be held longer than a minimum time and then released. Once armed, the block raises both interrupt requests toward the CPU. It then watches the bus for the stack pushes that the CPU makes on every interrupt entry.

Three back-to-back writes into the stack page mean the vector fetch comes next. On the clock edge that completes that third write, the block enters the frozen state. That state tells the address decoder to switch to the freeze map and tells the register block to lock the cartridge control lines. The frozen state ends only on a single-cycle exit pulse from the register block, or on reset.

The block has no timeout. If the frozen program never services an interrupt, the block stays armed and the memory map is never touched. Freezing can be inhibited by a software disable bit or by the programming jumper. The button level is always passed through so that software can read it.

Top module: `freeze_seq`

## Requirements
- R1: After reset is asserted, irq_req_o, nmi_req_o and frozen_o are all 0.
- R2: A button press held high for more than HOLD_CYC clock cycles arms the block on the cycle the button returns low. HOLD_CYC is the hold time in ns times the clock rate. irq_req_o rises after the clock edge at which the low button level is sampled.
- R3: A press of HOLD_CYC cycles or fewer does not arm the block. Any low cycle restarts the count, so two short presses do not add up.
- R4: While the block is armed, irq_req_o and nmi_req_o are both 1. Both drop on the same edge at which frozen_o rises.
- R5: While armed, three consecutive bus cycles that are writes with address bits [15:8] equal to 0x01 set frozen_o. A bus cycle is a clock with bus_valid_i = 1, and rnw_i = 0 marks a write. A read or a write outside the stack page restarts the run. Clocks with bus_valid_i = 0 do not restart it.
- R6: There is no timeout. The block stays armed without limit while no qualifying stack-write run occurs.
- R7: While frozen_o is 1, button presses have no effect. frozen_o clears only on exit_i = 1 or on reset.
- R8: While no_freeze_i or flash_jmp_i is 1, a qualified press does not arm the block. btn_level_o always equals btn_i.
- R9: Stack writes while the block is not armed do not count toward a run.
- R10: exit_i while the block is not frozen has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| btn_i | input | 1 | Synchronized freeze button, 1 = pressed |
| addr_i | input | ADDR_W | CPU address bus |
| rnw_i | input | 1 | CPU read/write, 1 = read |
| bus_valid_i | input | 1 | PHI2-qualified strobe, one clock per CPU bus cycle |
| no_freeze_i | input | 1 | Software freeze disable |
| flash_jmp_i | input | 1 | Programming jumper fitted, also disables freezing |
| exit_i | input | 1 | One-cycle end-of-freeze pulse from the register block |
| irq_req_o | output | 1 | IRQ request toward the CPU |
| nmi_req_o | output | 1 | NMI request toward the CPU |
| frozen_o | output | 1 | Freeze map active and control lines locked |
| btn_level_o | output | 1 | Raw button level for readback |

## Verification
The hardest case to reach from the ports is a stack-write run that is broken in each possible way just before it completes. The break can come from a read inside the page, from a write outside the page, or from idle clocks between bus cycles, which must not break it. The stimulus reaches this case by arming the block and then issuing individual bus cycles, checking frozen_o after each one. A behavioural model follows the hold count and the run length as plain integers and is compared with the outputs on every clock. The stimulus also covers press lengths one cycle either side of the hold threshold and presses that land while frozen or inhibited.

// File: rtl/freeze_pkg.sv
package freeze_pkg;
  localparam logic [7:0] STACK_PAGE = 8'h01;
  localparam int         STACK_RUN  = 3;

  function automatic int hold_cycles(input int clk_hz, input int hold_ns);
    return (clk_hz / 1000) * hold_ns / 1_000_000;
  endfunction
endpackage

// File: rtl/btn_qualifier.sv
module btn_qualifier #(
  parameter int HOLD_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic arm_o
);
  localparam int SAT   = HOLD_CYC + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  logic [CNT_W-1:0] cnt_q;

  // count consecutive high cycles, saturate once the press is long enough
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!btn_i)               cnt_q <= '0;
    else if (cnt_q != CNT_W'(SAT)) cnt_q <= cnt_q + 1'b1;
  end

  assign arm_o = !btn_i && (cnt_q == CNT_W'(SAT));

  assert_arm_after_press_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_o |-> $past(btn_i));
  assert_no_arm_while_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_i |-> !arm_o);
endmodule

// File: rtl/stack_watch.sv
module stack_watch
  import freeze_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pending_i,
  input  logic              bus_valid_i,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int RUN_W = $clog2(STACK_RUN);

  logic [RUN_W-1:0] run_q;
  logic             stk_wr;

  assign stk_wr = !rnw_i && ((addr_i >> 8) == ADDR_W'(STACK_PAGE));
  assign hit_o  = pending_i && bus_valid_i && stk_wr
                  && (run_q == RUN_W'(STACK_RUN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (!pending_i || hit_o) run_q <= '0;
    else if (bus_valid_i)         run_q <= stk_wr ? run_q + 1'b1 : '0;
  end

  assert_idle_unarmed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_i |=> (run_q == '0));
  assert_break_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !stk_wr) |=> (run_q == '0));
endmodule

// File: rtl/freeze_core.sv
module freeze_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic hit_i,
  input  logic no_freeze_i,
  input  logic flash_jmp_i,
  input  logic exit_i,
  output logic pending_o,
  output logic done_o
);
  logic pending_q, done_q, arm_ok;

  assign arm_ok = arm_i && !no_freeze_i && !flash_jmp_i && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (hit_i)       pending_q <= 1'b0;
      else if (arm_ok) pending_q <= 1'b1;
      if (hit_i)       done_q    <= 1'b1;
      else if (exit_i) done_q    <= 1'b0;
    end
  end

  assign pending_o = pending_q;
  assign done_o    = done_q;

  assert_done_drops_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !pending_q);
  assert_done_needs_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_q && !pending_q) |=> !done_q);
  assert_done_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !exit_i) |=> done_q);
  assert_inhibit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((no_freeze_i || flash_jmp_i) && !pending_q) |=> !pending_q);
  assert_exit_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_i && !done_q && !pending_q && !arm_i) |=> (!done_q && !pending_q));
endmodule

// File: rtl/freeze_seq.sv
module freeze_seq
  import freeze_pkg::*;
#(
  parameter int CLK_HZ  = 32_000_000,
  parameter int HOLD_NS = 2000,
  parameter int ADDR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              btn_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rnw_i,
  input  logic              bus_valid_i,
  input  logic              no_freeze_i,
  input  logic              flash_jmp_i,
  input  logic              exit_i,
  output logic              irq_req_o,
  output logic              nmi_req_o,
  output logic              frozen_o,
  output logic              btn_level_o
);
  localparam int HOLD_CYC = hold_cycles(CLK_HZ, HOLD_NS);

  logic arm, hit, pending, done;

  btn_qualifier #(.HOLD_CYC(HOLD_CYC)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .btn_i(btn_i), .arm_o(arm)
  );

  stack_watch #(.ADDR_W(ADDR_W)) u_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .pending_i(pending),
    .bus_valid_i(bus_valid_i), .rnw_i(rnw_i), .addr_i(addr_i), .hit_o(hit)
  );

  freeze_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .hit_i(hit),
    .no_freeze_i(no_freeze_i), .flash_jmp_i(flash_jmp_i), .exit_i(exit_i),
    .pending_o(pending), .done_o(done)
  );

  assign irq_req_o   = pending;
  assign nmi_req_o   = pending;
  assign frozen_o    = done;
  assign btn_level_o = btn_i;

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_req_o && !frozen_o));
  assert_req_frozen_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_req_o && frozen_o));
endmodule

// File: tb/freeze_seq_bench.sv
module freeze_seq_bench;
  localparam int CLK_HZ  = 100_000_000;
  localparam int HOLD_NS = 200;
  localparam int HOLD    = 20;

  logic        clk = 0, rst_n = 0;
  logic        btn = 0, rnw = 1, valid = 0, nf = 0, fl = 0, ex = 0;
  logic [15:0] addr = 16'h0000;
  logic        irq, nmi, frz, lvl;

  int checks = 0, errors = 0, cycles = 0;
  int m_hold = 0, m_run = 0;
  bit m_pend = 0, m_done = 0;

  always #5 clk = ~clk;

  freeze_seq #(.CLK_HZ(CLK_HZ), .HOLD_NS(HOLD_NS), .ADDR_W(16)) u_freeze_seq (
    .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .addr_i(addr), .rnw_i(rnw),
    .bus_valid_i(valid), .no_freeze_i(nf), .flash_jmp_i(fl), .exit_i(ex),
    .irq_req_o(irq), .nmi_req_o(nmi), .frozen_o(frz), .btn_level_o(lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference, evaluated on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 0; m_run = 0; m_pend = 0; m_done = 0;
    end else begin
      bit arm, hit, swr;
      arm = !btn && m_hold > HOLD && !nf && !fl && !m_done;
      swr = valid && !rnw && addr[15:8] == 8'h01;
      hit = m_pend && swr && m_run == 2;
      if (!m_pend || hit) m_run = 0;
      else if (valid)     m_run = swr ? m_run + 1 : 0;
      m_hold = btn ? m_hold + 1 : 0;
      if (hit) begin m_done = 1; m_pend = 0; end
      else begin
        if (arm) m_pend = 1;
        if (ex)  m_done = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 irq vs model", irq, m_pend);
      chk("R4 nmi vs model", nmi, m_pend);
      chk("R5 frozen vs model", frz, m_done);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", cycles, 200000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int n);
    @(negedge clk); btn = 1;
    repeat (n) @(negedge clk);
    btn = 0;
  endtask

  task automatic bus(input logic [15:0] a, input logic r);
    @(negedge clk); valid = 1; addr = a; rnw = r;
    @(negedge clk); valid = 0; rnw = 1;
  endtask

  task automatic pulse_exit();
    @(negedge clk); ex = 1;
    @(negedge clk); ex = 0;
  endtask

  task automatic freeze_now();
    bus(16'h01F0, 0); bus(16'h01EF, 0); bus(16'h01EE, 0);
  endtask

  initial begin
    cyc(3);
    chk("R1 irq in reset", irq, 0);
    chk("R1 frozen in reset", frz, 0);
    @(negedge clk); rst_n = 1;
    cyc(2);

    press(HOLD); cyc(2);
    chk("R3 press at threshold", irq, 0);
    press(15); press(15); cyc(2);
    chk("R3 bounced press", irq, 0);

    nf = 1;
    @(negedge clk); btn = 1; #1;
    chk("R8 level readback high", lvl, 1);
    repeat (HOLD + 5) @(negedge clk);
    btn = 0; #1;
    chk("R8 level readback low", lvl, 0);
    cyc(2);
    chk("R8 no_freeze inhibits", irq, 0);
    nf = 0; fl = 1;
    press(HOLD + 5); cyc(2);
    chk("R8 jumper inhibits", irq, 0);
    fl = 0;

    freeze_now(); cyc(1);
    chk("R9 stack writes unarmed", frz, 0);

    press(HOLD + 1); cyc(1);
    chk("R2 armed irq", irq, 1);
    chk("R4 armed nmi", nmi, 1);
    cyc(500);
    chk("R6 still armed", irq, 1);
    chk("R6 map untouched", frz, 0);

    bus(16'h01FF, 0); bus(16'h01FE, 0); bus(16'h0100, 1);
    bus(16'h01FD, 0); bus(16'h0234, 0);
    bus(16'h01FC, 0); cyc(4); bus(16'h01FB, 0);
    chk("R5 two writes only", frz, 0);
    bus(16'h01FA, 0);
    chk("R5 third write freezes", frz, 1);
    chk("R4 irq drops on freeze", irq, 0);

    press(HOLD + 5); cyc(3);
    chk("R7 button ignored frozen", frz, 1);
    chk("R7 no rearm frozen", irq, 0);
    pulse_exit();
    chk("R7 exit clears", frz, 0);
    pulse_exit(); cyc(1);
    chk("R10 exit idle frozen", frz, 0);
    chk("R10 exit idle irq", irq, 0);

    press(HOLD + 2); cyc(1);
    chk("R2 rearm", irq, 1);
    freeze_now();
    chk("R5 second freeze", frz, 1);
    @(negedge clk); rst_n = 0; #1;
    chk("R1 reset clears frozen", frz, 0);
    cyc(2); rst_n = 1; cyc(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule